// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a 64-bit linear address into a physical address. It reads 64-bit translation entries from memory, one level at a time, through a request/response port that allows one read in flight. The walk begins at level 4 when five-level mode is selected and at level 3 otherwise. Level 0 is the last-level table. Each entry is checked for presence and for reserved bits. The walk stops at a leaf: level 0 always, or level 1 or 2 when the entry flags a large page.

When a walk completes, the block gives the physical address and the write and user rights combined along the path. It also gives two level masks: one marks the entries whose accessed flag must be set, the other the entry whose dirty flag must be set. A failed walk gives a fault pulse and the level at which it stopped. The walker serves one request at a time. Mode, root, no-execute enable and access type are captured when a request is accepted.

Top module: `ptw_walker`

## Requirements
- R1: While reset is high and after its release, busy, mem_req_valid, walk_done and walk_fault are all 0 until a request is accepted.
- R2: With five_level=1 a walk that ends at level 0 makes exactly 5 entry reads, and with five_level=0 it makes 4. A walk ending at level L makes (start-L+1) reads, where start is 4 or 3.
- R3: The read address at level L is base + ((vaddr >> (9+9L)) & 0xFF8). For the first read, base is root_base bits 51:12 with the low 12 bits cleared. After that, base is bits 51:12 of the previous entry with the low 12 bits cleared.
- R4: A leaf is level 0, or level 1 or 2 with entry bit 7 set. Let mask = 2^(12+9·leaf) − 1. Then phys_addr = (entry bits 51:12 with the low 12 bits cleared, AND NOT mask) OR (vaddr AND mask).
- R5: If entry bit 0 is clear, the walk ends with a walk_fault pulse. fault_level gives that level and phys_addr reads 0.
- R6: If any entry bit from 52 to 62 is set, or bit 7 is set at level 3 or 4, the walk faults at that level.
- R7: With nx_enable=0, entry bit 63 is a reserved bit and causes a fault. With nx_enable=1, bit 63 does not affect the walk.
- R8: perm_write is the AND of bit 1, and perm_user the AND of bit 2, over every entry read in the walk.
- R9: On walk_done, bit i of acc_mask is 1 exactly for start ≥ i ≥ leaf. dirty_mask has only the leaf bit set for a write request, and is 0 for a read request.
- R10: busy rises when a request is accepted and falls in the cycle the done or fault pulse appears. A req_valid seen while busy starts no walk.
- R11: five_level, root_base, nx_enable and req_write are sampled only when a request is accepted. Changing them during a walk has no effect on that walk.
- R12: mem_req_valid lasts one cycle per level. The next read is issued only after the response to the previous one.
- R13: walk_done and walk_fault are one-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request, accepted when idle |
| req_vaddr | input | 64 | Linear address to translate |
| req_write | input | 1 | Request is a write access |
| root_base | input | 64 | Root table register, bits 51:12 used |
| five_level | input | 1 | Start the walk at level 4 instead of 3 |
| nx_enable | input | 1 | No-execute enabled; bit 63 is not reserved |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Entry read request (one-cycle pulse) |
| mem_req_addr | output | 52 | Physical address of the entry |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 64 | Entry read data |
| walk_done | output | 1 | Translation complete pulse |
| walk_fault | output | 1 | Translation fault pulse |
| fault_level | output | 3 | Level at which the fault occurred |
| phys_addr | output | 52 | Translated physical address |
| acc_mask | output | 5 | Levels needing the accessed flag set |
| dirty_mask | output | 5 | Level needing the dirty flag set |
| perm_write | output | 1 | Combined write permission |
| perm_user | output | 1 | Combined user permission |

## Verification
A new request can arrive in the same cycle that a memory response is consumed mid-walk. To provoke this, the bench raises req_valid with a complemented address on the response edge of every level, and it scrambles mode, root and no-execute enable for the whole walk. The result is judged against a reference walk built from the operands captured at acceptance. In each case the bench also checks that the port stays idle, with no read and no busy, for several cycles after the done or fault pulse.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int ENT_W         = 64;
    localparam int PAGE_SHIFT    = 12;
    localparam int IDX_W         = 9;
    localparam int ENT_BYTES_LOG = 3;

    // entry flag positions
    localparam int B_PRESENT = 0;
    localparam int B_WRITE   = 1;
    localparam int B_USER    = 2;
    localparam int B_BIG     = 7;
    localparam int B_NOEXEC  = 63;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } walk_st_e;

    typedef struct packed {
        logic present;
        logic rsvd;
        logic leaf;
    } ent_verdict_t;

    function automatic logic [ENT_W-1:0] low_ones(input int unsigned n);
        if (n >= ENT_W) return '1;
        return (ENT_W'(1) << n) - ENT_W'(1);
    endfunction

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
    import ptw_pkg::*;
#(
    parameter int PA_W  = 52,
    parameter int LA_W  = 64,
    parameter int LVL_W = 3
) (
    input  logic [PA_W-1:0]  table_base,
    input  logic [LA_W-1:0]  lin_addr,
    input  logic [LVL_W-1:0] level,
    output logic [PA_W-1:0]  ent_addr
);
    localparam int SLOT_MSB = IDX_W + ENT_BYTES_LOG - 1;

    logic [LA_W-1:0] shifted;
    logic            unused_hi;

    always_comb begin
        shifted  = lin_addr >> (PAGE_SHIFT - ENT_BYTES_LOG + IDX_W * int'(level));
        ent_addr = table_base
                 + PA_W'({shifted[SLOT_MSB:ENT_BYTES_LOG], {ENT_BYTES_LOG{1'b0}}});
    end

    assign unused_hi = ^{shifted[LA_W-1:SLOT_MSB+1], shifted[ENT_BYTES_LOG-1:0]};

endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
    import ptw_pkg::*;
#(
    parameter int PA_W    = 52,
    parameter int LVL_W   = 3,
    parameter int BIG_MAX = 2
) (
    input  logic [ENT_W-1:0] entry,
    input  logic [LVL_W-1:0] level,
    input  logic             nx_en,
    output ent_verdict_t     verdict
);
    logic hi_rsvd;
    logic big_allowed;

    always_comb begin
        hi_rsvd = 1'b0;
        for (int b = PA_W; b < B_NOEXEC; b++) hi_rsvd = hi_rsvd | entry[b];
        big_allowed     = (int'(level) >= 1) && (int'(level) <= BIG_MAX);
        verdict.present = entry[B_PRESENT];
        verdict.rsvd    = hi_rsvd
                        | (~nx_en & entry[B_NOEXEC])
                        | (entry[B_BIG] & (int'(level) > BIG_MAX));
        verdict.leaf    = (level == '0) | (entry[B_BIG] & big_allowed);
    end

endmodule

// File: rtl/ptw_span_mask.sv
module ptw_span_mask #(
    parameter int NLVL  = 5,
    parameter int LVL_W = 3
) (
    input  logic [LVL_W-1:0] top_lvl,
    input  logic [LVL_W-1:0] bottom_lvl,
    output logic [NLVL-1:0]  span
);
    for (genvar i = 0; i < NLVL; i++) begin : g_lvl
        assign span[i] = (LVL_W'(i) <= top_lvl) && (LVL_W'(i) >= bottom_lvl);
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int PA_W      = 52,
    parameter int LA_W      = 64,
    parameter int NLVL      = 5,
    parameter int WIDE_LA   = 57,
    parameter int NARROW_LA = 48,
    parameter int BIG_MAX   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [LA_W-1:0]          req_vaddr,
    input  logic                     req_write,
    input  logic [ENT_W-1:0]         root_base,
    input  logic                     five_level,
    input  logic                     nx_enable,
    output logic                     busy,
    output logic                     mem_req_valid,
    output logic [PA_W-1:0]          mem_req_addr,
    input  logic                     mem_rsp_valid,
    input  logic [ENT_W-1:0]         mem_rsp_data,
    output logic                     walk_done,
    output logic                     walk_fault,
    output logic [$clog2(NLVL)-1:0]  fault_level,
    output logic [PA_W-1:0]          phys_addr,
    output logic [NLVL-1:0]          acc_mask,
    output logic [NLVL-1:0]          dirty_mask,
    output logic                     perm_write,
    output logic                     perm_user
);
    localparam int LVL_W = $clog2(NLVL);

    walk_st_e         st_q;
    logic [LVL_W-1:0] lvl_q, start_q;
    logic [LA_W-1:0]  va_q, omask_q, omask_n;
    logic [PA_W-1:0]  base_q, frame_n;
    logic             nx_q, wr_q, pw_q, pu_q;
    ent_verdict_t     verdict;
    logic [NLVL-1:0]  span;
    logic             unused_bits;

    ptw_entry_addr #(.PA_W(PA_W), .LA_W(LA_W), .LVL_W(LVL_W)) u_addr (
        .table_base (base_q),
        .lin_addr   (va_q),
        .level      (lvl_q),
        .ent_addr   (mem_req_addr)
    );

    ptw_entry_check #(.PA_W(PA_W), .LVL_W(LVL_W), .BIG_MAX(BIG_MAX)) u_check (
        .entry   (mem_rsp_data),
        .level   (lvl_q),
        .nx_en   (nx_q),
        .verdict (verdict)
    );

    ptw_span_mask #(.NLVL(NLVL), .LVL_W(LVL_W)) u_span (
        .top_lvl    (start_q),
        .bottom_lvl (lvl_q),
        .span       (span)
    );

    assign busy          = (st_q != ST_IDLE);
    assign mem_req_valid = (st_q == ST_ISSUE);
    assign omask_n       = omask_q >> IDX_W;
    assign frame_n       = {mem_rsp_data[PA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    assign unused_bits   = ^{root_base[ENT_W-1:PA_W], root_base[PAGE_SHIFT-1:0],
                             mem_rsp_data[PAGE_SHIFT-1:B_BIG+1], mem_rsp_data[B_BIG-1:B_USER+1],
                             omask_n[LA_W-1:PA_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            lvl_q       <= '0;
            start_q     <= '0;
            va_q        <= '0;
            omask_q     <= '0;
            base_q      <= '0;
            nx_q        <= 1'b0;
            wr_q        <= 1'b0;
            pw_q        <= 1'b0;
            pu_q        <= 1'b0;
            walk_done   <= 1'b0;
            walk_fault  <= 1'b0;
            fault_level <= '0;
            phys_addr   <= '0;
            acc_mask    <= '0;
            dirty_mask  <= '0;
            perm_write  <= 1'b0;
            perm_user   <= 1'b0;
        end else begin
            walk_done  <= 1'b0;
            walk_fault <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (req_valid) begin
                    st_q    <= ST_ISSUE;
                    lvl_q   <= LVL_W'(five_level ? NLVL - 1 : NLVL - 2);
                    start_q <= LVL_W'(five_level ? NLVL - 1 : NLVL - 2);
                    va_q    <= req_vaddr;
                    omask_q <= LA_W'(low_ones(five_level ? WIDE_LA : NARROW_LA));
                    base_q  <= {root_base[PA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
                    nx_q    <= nx_enable;
                    wr_q    <= req_write;
                    pw_q    <= 1'b1;
                    pu_q    <= 1'b1;
                end
                ST_ISSUE: st_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    omask_q <= omask_n;
                    pw_q    <= pw_q & mem_rsp_data[B_WRITE];
                    pu_q    <= pu_q & mem_rsp_data[B_USER];
                    if (!verdict.present || verdict.rsvd) begin
                        st_q        <= ST_IDLE;
                        walk_fault  <= 1'b1;
                        fault_level <= lvl_q;
                        phys_addr   <= '0;
                    end else if (verdict.leaf) begin
                        st_q       <= ST_IDLE;
                        walk_done  <= 1'b1;
                        phys_addr  <= (frame_n & ~omask_n[PA_W-1:0])
                                    | (va_q[PA_W-1:0] & omask_n[PA_W-1:0]);
                        acc_mask   <= span;
                        dirty_mask <= wr_q ? (NLVL'(1) << lvl_q) : '0;
                        perm_write <= pw_q & mem_rsp_data[B_WRITE];
                        perm_user  <= pu_q & mem_rsp_data[B_USER];
                    end else begin
                        st_q   <= ST_ISSUE;
                        base_q <= frame_n;
                        lvl_q  <= lvl_q - LVL_W'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int PA_W = 52,
    parameter int NLVL = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            mem_req_valid,
    input logic            walk_done,
    input logic            walk_fault,
    input logic [PA_W-1:0] phys_addr,
    input logic [NLVL-1:0] acc_mask,
    input logic [NLVL-1:0] dirty_mask
);
    p_issue_busy_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> busy);

    p_end_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (walk_done || walk_fault) |-> !busy);

    p_start_issue_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> mem_req_valid);

    p_single_issue_r12: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    p_pulse_excl_r13: assert property (@(posedge clk) disable iff (rst)
        walk_done |-> !walk_fault);

    p_done_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        walk_done |=> !walk_done);

    p_fault_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        walk_fault |=> !walk_fault);

    p_fault_noaddr_r5: assert property (@(posedge clk) disable iff (rst)
        walk_fault |-> (phys_addr == '0));

    p_dirty_leaf_r9: assert property (@(posedge clk) disable iff (rst)
        walk_done |-> ($onehot0(dirty_mask) && ((dirty_mask & ~acc_mask) == '0)));

    p_acc_nonempty_r9: assert property (@(posedge clk) disable iff (rst)
        walk_done |-> (acc_mask != '0));
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W), .NLVL(NLVL)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .walk_done     (walk_done),
    .walk_fault    (walk_fault),
    .phys_addr     (phys_addr),
    .acc_mask      (acc_mask),
    .dirty_mask    (dirty_mask)
);

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [63:0] root_base = '0;
    logic        five_level = 1'b0;
    logic        nx_enable = 1'b0;
    logic        busy, mem_req_valid;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        walk_done, walk_fault;
    logic [2:0]  fault_level;
    logic [51:0] phys_addr;
    logic [4:0]  acc_mask, dirty_mask;
    logic        perm_write, perm_user;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int walks  = 0;
    logic [63:0] ents [0:4];

    always #10 clk = ~clk;

    ptw_walker u_ptw_walker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .root_base(root_base), .five_level(five_level),
        .nx_enable(nx_enable), .busy(busy), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .walk_done(walk_done), .walk_fault(walk_fault),
        .fault_level(fault_level), .phys_addr(phys_addr), .acc_mask(acc_mask),
        .dirty_mask(dirty_mask), .perm_write(perm_write), .perm_user(perm_user)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (walk %0d)", tag, act, exp, walks);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // Reference walk computed from the requirements, with the bench acting as memory.
    task automatic run_walk(input logic [63:0] va, input bit five, input bit nx,
                            input bit wr, input logic [63:0] root, input string tag);
        int          l, start, reads, n, lat, leaf_l;
        logic [63:0] base, mask, e, exp_addr, exp_pa;
        bit          pw, pu, ended, exp_fault, rsvd;
        walks++;
        lat   = 1 + (walks % 3);
        start = five ? 4 : 3;
        l     = start;
        base  = {12'h0, root[51:12], 12'h0};
        mask  = five ? ((64'h1 << 57) - 1) : ((64'h1 << 48) - 1);
        pw = 1'b1; pu = 1'b1; reads = 0; ended = 1'b0; exp_fault = 1'b0;
        exp_pa = '0; leaf_l = 0;
        req_valid = 1'b1; req_vaddr = va; five_level = five; nx_enable = nx;
        req_write = wr; root_base = root;
        @(negedge clk);
        // scramble the sampled operands for the rest of the walk (R11)
        req_valid = 1'b0; req_vaddr = ~va; five_level = ~five; nx_enable = ~nx;
        req_write = ~wr; root_base = ~root;
        while (!ended) begin
            n = 0;
            while (!(mem_req_valid || walk_done || walk_fault) && n < 50) begin
                @(negedge clk); n++;
            end
            if (!mem_req_valid) begin
                chk(1'b0, "R2 R12 read missing", {63'h0, walk_done | walk_fault}, 64'h0);
                ended = 1'b1;
            end else begin
                reads++;
                exp_addr = base + ((va >> (9 + 9 * l)) & 64'hFF8);
                chk({12'h0, mem_req_addr} == exp_addr, "R3 R11 entry address",
                    {12'h0, mem_req_addr}, exp_addr);
                e = ents[l];
                repeat (lat) @(negedge clk);
                mem_rsp_valid = 1'b1; mem_rsp_data = e;
                req_valid = 1'b1;                       // stray request while busy (R10)
                @(negedge clk);
                mem_rsp_valid = 1'b0; mem_rsp_data = '0; req_valid = 1'b0;
                mask = mask >> 9;
                pw = pw & e[1];
                pu = pu & e[2];
                rsvd = (|e[62:52]) || (!nx && e[63]) || (l >= 3 && e[7]);
                if (!e[0] || rsvd) begin
                    exp_fault = 1'b1; leaf_l = l; ended = 1'b1;
                end else if (l == 0 || (l <= 2 && e[7])) begin
                    exp_pa = ({12'h0, e[51:12], 12'h0} & ~mask) | (va & mask);
                    leaf_l = l; ended = 1'b1;
                end else begin
                    base = {12'h0, e[51:12], 12'h0};
                    l--;
                end
            end
        end
        chk(reads == start - leaf_l + 1, "R2 R12 read count", 64'(reads), 64'(start - leaf_l + 1));
        chk(walk_fault == exp_fault && walk_done == !exp_fault, tag,
            {62'h0, walk_fault, walk_done}, {62'h0, exp_fault, !exp_fault});
        chk(busy == 1'b0, "R10 busy low at end pulse", {63'h0, busy}, 64'h0);
        if (exp_fault) begin
            chk(fault_level == 3'(leaf_l), "R5 fault level", {61'h0, fault_level}, 64'(leaf_l));
            chk(phys_addr == '0, "R5 no address on fault", {12'h0, phys_addr}, 64'h0);
        end else begin
            chk({12'h0, phys_addr} == exp_pa, "R4 physical address", {12'h0, phys_addr}, exp_pa);
            chk(perm_write == pw && perm_user == pu, "R8 combined rights",
                {62'h0, perm_write, perm_user}, {62'h0, pw, pu});
            chk(acc_mask == 5'((32'h1 << (start + 1)) - (32'h1 << leaf_l)), "R9 accessed mask",
                {59'h0, acc_mask}, 64'((32'h1 << (start + 1)) - (32'h1 << leaf_l)));
            chk(dirty_mask == (wr ? 5'(32'h1 << leaf_l) : 5'h0), "R9 dirty mask",
                {59'h0, dirty_mask}, wr ? 64'(32'h1 << leaf_l) : 64'h0);
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!walk_done && !walk_fault && !busy && !mem_req_valid,
                "R10 R13 idle after end pulse",
                {60'h0, walk_done, walk_fault, busy, mem_req_valid}, 64'h0);
        end
    endtask

    function automatic logic [63:0] mk_ent(input logic [39:0] frame, input bit p, input bit w,
                                           input bit u, input bit big);
        return {12'h0, frame, 4'h0, big, 4'h0, u, w, p};
    endfunction

    initial begin
        logic [63:0] va, root;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req_valid && !walk_done && !walk_fault, "R1 reset state",
            {60'h0, busy, mem_req_valid, walk_done, walk_fault}, 64'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy && !mem_req_valid && !walk_done && !walk_fault, "R1 after release",
            {60'h0, busy, mem_req_valid, walk_done, walk_fault}, 64'h0);

        // Sweep: mode x leaf level x access type x address pattern
        for (int five = 0; five < 2; five++)
            for (int leaf = 0; leaf < 3; leaf++)
                for (int wr = 0; wr < 2; wr++)
                    for (int p = 0; p < 3; p++) begin
                        va   = (64'h0123_4567_89AB_CDEF * 64'(p + 1)) ^ (64'h00F0_0000_0000_0000 * 64'(leaf));
                        root = 64'hFFF0_0000_0000_0ABC | (64'(p + 7) << 20);
                        for (int l = 0; l < 5; l++)
                            ents[l] = mk_ent(40'h12_3456_7800 + 40'(l) * 40'h1_0001 + 40'(p) * 40'h3_0303,
                                             1'b1, ((p + l) % 3) != 0, ((p + 2 * l) % 4) != 3,
                                             (l == leaf) && (leaf > 0));
                        run_walk(va, five[0], 1'b1, wr[0], root, "R2 R4 normal walk outcome");
                    end

        // Faults and no-execute handling at every level
        for (int five = 0; five < 2; five++)
            for (int f = (five ? 4 : 3); f >= 0; f--)
                for (int kind = 0; kind < 5; kind++) begin
                    if (kind == 4 && f < 3) continue;
                    for (int l = 0; l < 5; l++)
                        ents[l] = mk_ent(40'h0A_BCDE_F000 + 40'(l) * 40'h101, 1'b1, 1'b1, 1'b1, 1'b0);
                    va = 64'hFEDC_BA98_7654_3210 ^ (64'(f) << 40);
                    case (kind)
                        0: begin ents[f][0] = 1'b0;
                                 run_walk(va, five[0], 1'b1, 1'b1, 64'h5000, "R5 non-present"); end
                        1: begin ents[f][52 + f * 2] = 1'b1;
                                 run_walk(va, five[0], 1'b1, 1'b0, 64'h5000, "R6 reserved high bit"); end
                        2: begin ents[f][63] = 1'b1;
                                 run_walk(va, five[0], 1'b0, 1'b0, 64'h5000, "R7 NX reserved when disabled"); end
                        3: begin ents[f][63] = 1'b1;
                                 run_walk(va, five[0], 1'b1, 1'b1, 64'h5000, "R7 NX allowed when enabled"); end
                        default: begin ents[f][7] = 1'b1;
                                 run_walk(va, five[0], 1'b1, 1'b0, 64'h5000, "R6 large flag at upper level"); end
                    endcase
                end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule